// File: doc/BRIEF.md
# Nanosecond Timer with Wrap-Safe Output-Compare Channel

This block keeps a free-running nanosecond count within one second. On every clock the count grows by a fixed step (25 ns by default, for a 40 MHz clock). When the next step would reach one second, the count returns to zero. A single output-compare channel watches the count and toggles a pin each time the count reaches or steps past a programmed compare value. This produces a media clock whose edges follow a list of timestamps.

Compare values enter through a double buffer. Software writes them through a small register port, or a DMA engine streams them in over a valid/ready port. Each match does four things: it toggles the pin, sets a sticky flag, drives the interrupt, and promotes the buffered value, which frees the buffer and signals the stream side to send the next timestamp.

The match test compares the whole step the count takes on each clock, and it knows about the wrap. A value that lies between two count values, or in the last step before one second, or just after zero, is never skipped. If no new value is ready when a match fires, the channel keeps its old value and stays armed. The next value written rearms it at once.

Top module: `nsoc_timer_channel`

## Requirements
- R1: When TIME is not being written, the count grows by INC_NS (25) on every clock while it is below PERIOD_NS-INC_NS.
- R2: When the count is at or above PERIOD_NS-INC_NS (999,999,975), the next clock sets it to 0. The count is always below PERIOD_NS. Writing TIME loads the written value on the next edge, and a written value of PERIOD_NS or more loads 0.
- R3: A match fires on a non-wrapping step from t to t+INC_NS when t < C <= t+INC_NS. It fires on a wrapping step from t to 0 when C > t or C == 0. C is the active compare value. No match is tested on an edge that loads TIME. A value written below the present count therefore fires after the next wrap.
- R4: oc_out toggles on the edge of every match and holds its level at all other times. Its reset level is 0.
- R5: Each match sets the flag (STAT bit 0). Writing STAT with bit 0 = 1 clears the flag, and writing bit 0 = 0 leaves it unchanged. If a match and a clear happen in the same cycle, the set wins.
- R6: Double buffer. A value written while the channel is disabled waits in the buffer (STAT bit 3 = 1). Enabling the channel (CTRL bit 0 going from 0 to 1) moves the buffer into the active stage and arms the channel (STAT bit 2 = 1). At every match, a full buffer moves into the active stage.
- R7: If the buffer is empty when a match fires, the active value stays and the channel stays armed in a starved state (STAT bit 4 = 1). The next accepted value goes straight to the active stage and ends the starved state.
- R8: cmp_ready is high exactly when the channel is enabled, the buffer is empty and no software write to CMP happens in the same cycle. A value is taken when cmp_valid and cmp_ready are both high. While the buffer is full, cmp_ready stays low and the source must hold cmp_valid and cmp_data until a match frees the buffer.
- R9: While enabled, a write to CMP (or an accepted stream value) goes straight to the active stage when the channel is unarmed or starved. Otherwise it goes into the buffer, replacing any value already there.
- R10: Writing CTRL bit 0 = 0 while enabled clears the active stage, the buffer and the armed and starved states. oc_out holds its level, CMP reads 0 and cmp_ready is low.
- R11: Any loaded start value works. From a start of 24 (or any value congruent to 24 mod 25), the count passes 999,999,999, wraps to 0, and later compare values still fire.
- R12: Register addresses: 0 = CTRL (bit 0 enable), 1 = TIME (read the count, write to load it), 2 = CMP (write a compare value, read the active value), 3 = STAT (bit 0 flag, bit 1 output level, bit 2 armed, bit 3 buffer full, bit 4 starved). After reset, every register reads 0.
- R13: irq equals the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address |
| reg_wdata | input | DW | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | DW | Read data, combinational from reg_raddr |
| cmp_valid | input | 1 | Stream compare value valid |
| cmp_data | input | DW | Stream compare value |
| cmp_ready | output | 1 | Buffer can take a value (next-timestamp request) |
| oc_out | output | 1 | Compare output, toggles on each match |
| irq | output | 1 | Interrupt, equal to the flag |

## Verification
The bound checker tests the properties that hold on every clock: the count steps by the increment, returns to zero at the top of the range and never leaves it, oc_out changes only on a match, a match sets the flag and leaves the channel armed, and the stream never signals ready while disabled or full. The match rule itself can only be shown in the bench's scenarios, which load the count near chosen points and read the time at which the pin toggles. These scenarios cover compare values that are not multiples of the step, values inside the last step before one second, values just after zero, values already passed and a start offset of 24. The bench scenarios also show the order in which the double buffer promotes values, recovery from the starved state, and the effect of clearing the flag by writing 1.

// File: rtl/nsoc_pkg.sv
package nsoc_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TIME = 2'd1;
  localparam logic [1:0] ADDR_CMP  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int unsigned STAT_FLAG    = 0;
  localparam int unsigned STAT_LEVEL   = 1;
  localparam int unsigned STAT_ARMED   = 2;
  localparam int unsigned STAT_FULL    = 3;
  localparam int unsigned STAT_STARVED = 4;
  localparam int unsigned STAT_BITS    = 5;

  typedef struct packed {
    logic starved;
    logic full;
    logic armed;
    logic level;
    logic flag;
  } stat_t;
endpackage

// File: rtl/ns_time_counter.sv
module ns_time_counter #(
  parameter int unsigned PERIOD_NS = 1_000_000_000,
  parameter int unsigned INC_NS    = 25,
  parameter int unsigned DW        = 32,
  localparam int unsigned TW       = $clog2(PERIOD_NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [TW-1:0] time_q,
  output logic [TW-1:0] time_next,
  output logic          wrapping
);
  localparam logic [TW-1:0] TOP = TW'(PERIOD_NS - INC_NS);
  localparam logic [TW-1:0] STEP = TW'(INC_NS);

  always_comb begin
    if (time_q >= TOP) begin
      time_next = '0;
      wrapping  = 1'b1;
    end else begin
      time_next = time_q + STEP;
      wrapping  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (load) begin
      time_q <= (load_val < DW'(PERIOD_NS)) ? load_val[TW-1:0] : '0;
    end else begin
      time_q <= time_next;
    end
  end
endmodule

// File: rtl/oc_match_detect.sv
module oc_match_detect #(
  parameter int unsigned PERIOD_NS = 1_000_000_000,
  parameter int unsigned INC_NS    = 25,
  parameter int unsigned DW        = 32,
  localparam int unsigned TW       = $clog2(PERIOD_NS)
) (
  input  logic [TW-1:0] time_q,
  input  logic [TW-1:0] time_next,
  input  logic          wrapping,
  input  logic          advance,
  input  logic          armed,
  input  logic [DW-1:0] cmp_val,
  output logic          hit
);
  logic [DW-1:0] cur_w, nxt_w;
  logic          step_hit, wrap_hit;

  assign cur_w = DW'(time_q);
  assign nxt_w = DW'(time_next);

  generate
    if (INC_NS == 1) begin : g_unit_step
      assign step_hit = (cmp_val == nxt_w);
    end else begin : g_window_step
      assign step_hit = (cmp_val > cur_w) && (cmp_val <= nxt_w);
    end
  endgenerate

  assign wrap_hit = (cmp_val > cur_w) || (cmp_val == '0);
  assign hit      = armed && advance && (wrapping ? wrap_hit : step_hit);
endmodule

// File: rtl/oc_compare_buffer.sv
module oc_compare_buffer #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          en_rise,
  input  logic          en_fall,
  input  logic          fire,
  input  logic          push,
  input  logic [DW-1:0] push_val,
  output logic [DW-1:0] active,
  output logic          armed,
  output logic          full,
  output logic          starved
);
  logic [DW-1:0] hold;
  logic          direct;

  assign direct = push && en && (!armed || starved);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= '0;
      hold    <= '0;
      armed   <= 1'b0;
      full    <= 1'b0;
      starved <= 1'b0;
    end else if (en_fall) begin
      active  <= '0;
      hold    <= '0;
      armed   <= 1'b0;
      full    <= 1'b0;
      starved <= 1'b0;
    end else if (en_rise) begin
      if (full) begin
        active <= hold;
        armed  <= 1'b1;
        full   <= 1'b0;
      end
    end else if (direct) begin
      active  <= push_val;
      armed   <= 1'b1;
      starved <= 1'b0;
    end else if (fire) begin
      if (full) begin
        active <= hold;
        if (push) hold <= push_val;
        else      full <= 1'b0;
      end else if (push) begin
        active <= push_val;
      end else begin
        starved <= 1'b1;
      end
    end else if (push) begin
      hold <= push_val;
      full <= 1'b1;
    end
  end
endmodule

// File: rtl/nsoc_timer_channel.sv
module nsoc_timer_channel #(
  parameter int unsigned PERIOD_NS = 1_000_000_000,
  parameter int unsigned INC_NS    = 25,
  parameter int unsigned DW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [1:0]    reg_raddr,
  output logic [DW-1:0] reg_rdata,
  input  logic          cmp_valid,
  input  logic [DW-1:0] cmp_data,
  output logic          cmp_ready,
  output logic          oc_out,
  output logic          irq
);
  import nsoc_pkg::*;

  localparam int unsigned TW = $clog2(PERIOD_NS);

  logic          wr_ctrl, wr_time, wr_cmp, wr_stat;
  logic          en_q, en_rise, en_fall;
  logic [TW-1:0] time_q, time_next;
  logic          wrapping, hit, fire;
  logic          push, accept;
  logic [DW-1:0] push_val, active;
  logic          armed, buf_full, starved;
  logic          flag_q;
  stat_t         stat;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_time = reg_wr && (reg_addr == ADDR_TIME);
  assign wr_cmp  = reg_wr && (reg_addr == ADDR_CMP);
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);

  assign en_rise = wr_ctrl &&  reg_wdata[0] && !en_q;
  assign en_fall = wr_ctrl && !reg_wdata[0] &&  en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (wr_ctrl) en_q <= reg_wdata[0];
  end

  ns_time_counter #(
    .PERIOD_NS(PERIOD_NS), .INC_NS(INC_NS), .DW(DW)
  ) u_count (
    .clk(clk), .rst_n(rst_n), .load(wr_time), .load_val(reg_wdata),
    .time_q(time_q), .time_next(time_next), .wrapping(wrapping)
  );

  oc_match_detect #(
    .PERIOD_NS(PERIOD_NS), .INC_NS(INC_NS), .DW(DW)
  ) u_match (
    .time_q(time_q), .time_next(time_next), .wrapping(wrapping),
    .advance(!wr_time), .armed(armed), .cmp_val(active), .hit(hit)
  );

  assign fire = hit && !en_fall;

  assign cmp_ready = en_q && !buf_full && !wr_cmp;
  assign accept    = cmp_valid && cmp_ready;
  assign push      = wr_cmp || accept;
  assign push_val  = wr_cmp ? reg_wdata : cmp_data;

  oc_compare_buffer #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .en(en_q), .en_rise(en_rise), .en_fall(en_fall),
    .fire(fire), .push(push), .push_val(push_val),
    .active(active), .armed(armed), .full(buf_full), .starved(starved)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      oc_out <= 1'b0;
    end else begin
      if (fire)                         flag_q <= 1'b1;
      else if (wr_stat && reg_wdata[0]) flag_q <= 1'b0;
      if (fire) oc_out <= !oc_out;
    end
  end

  assign irq = flag_q;

  always_comb begin
    stat.flag    = flag_q;
    stat.level   = oc_out;
    stat.armed   = armed;
    stat.full    = buf_full;
    stat.starved = starved;
  end

  always_comb begin
    unique case (reg_raddr)
      ADDR_CTRL: reg_rdata = DW'(en_q);
      ADDR_TIME: reg_rdata = DW'(time_q);
      ADDR_CMP:  reg_rdata = active;
      default:   reg_rdata = DW'(stat);
    endcase
  end
endmodule

// File: rtl/nsoc_timer_checker.sv
module nsoc_timer_checker #(
  parameter int unsigned PERIOD_NS = 1_000_000_000,
  parameter int unsigned INC_NS    = 25,
  parameter int unsigned TW        = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic [TW-1:0] time_q,
  input logic          fire,
  input logic          oc_out,
  input logic          irq,
  input logic          cmp_ready,
  input logic          buf_full,
  input logic          en_q,
  input logic          armed
);
  localparam logic [TW-1:0] TOP  = TW'(PERIOD_NS - INC_NS);
  localparam logic [TW-1:0] STEP = TW'(INC_NS);
  localparam logic [TW-1:0] LIM  = TW'(PERIOD_NS);

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && time_q < TOP) |=> time_q == $past(time_q) + STEP);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && time_q >= TOP) |=> time_q == '0);

  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    time_q < LIM);

  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> oc_out != $past(oc_out));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(oc_out));

  p_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq);

  p_still_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> armed);

  p_full_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !cmp_ready);

  p_off_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !cmp_ready);
endmodule

bind nsoc_timer_channel nsoc_timer_checker #(
  .PERIOD_NS(PERIOD_NS), .INC_NS(INC_NS), .TW(TW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load(wr_time), .time_q(time_q), .fire(fire),
  .oc_out(oc_out), .irq(irq), .cmp_ready(cmp_ready), .buf_full(buf_full),
  .en_q(en_q), .armed(armed)
);

// File: tb/nsoc_timer_channel_test.sv
module nsoc_timer_channel_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_TIME = 2'd1, A_CMP = 2'd2, A_STAT = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_data = '0;
  logic        cmp_ready, oc_out, irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nsoc_timer_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .cmp_valid(cmp_valid), .cmp_data(cmp_data), .cmp_ready(cmp_ready),
    .oc_out(oc_out), .irq(irq)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_raddr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic stream_push(input logic [31:0] d);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_data = d;
    #1;
    while (!cmp_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic wait_toggle(input string req, input longint exp_time, input logic exp_lvl);
    logic prev;
    logic [31:0] t;
    bit seen;
    prev = oc_out;
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (oc_out !== prev) begin
        seen = 1;
        break;
      end
    end
    check(req, "toggle seen", seen, 1);
    rd(A_TIME, t);
    check(req, "time at toggle", t, exp_time);
    check("R4", "level after toggle", oc_out, exp_lvl);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_TIME, v);  check("R12", "time after reset", v, 0);
    rd(A_STAT, v);  check("R12", "stat after reset", v, 0);
    rd(A_CMP, v);   check("R12", "cmp after reset", v, 0);
    check("R13", "irq after reset", irq, 0);
    check("R8", "ready after reset", cmp_ready, 0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    reg_write(A_TIME, 1000);
    rd(A_TIME, v); check("R2", "loaded time", v, 1000);
    repeat (4) @(negedge clk);
    rd(A_TIME, v); check("R1", "time after 4 steps", v, 1100);
    reg_write(A_TIME, 32'd1_500_000_000);
    rd(A_TIME, v); check("R2", "out-of-range load", v, 0);
    reg_write(A_TIME, 32'd999_999_950);
    @(negedge clk);
    rd(A_TIME, v); check("R1", "step to top", v, 999_999_975);
    @(negedge clk);
    rd(A_TIME, v); check("R2", "wrap to zero", v, 0);
  endtask

  task automatic t_enable_and_starve;
    logic [31:0] v;
    reg_write(A_TIME, 5000);
    reg_write(A_CMP, 5200);
    rd(A_STAT, v); check("R6", "buffered while off", v[3], 1);
    reg_write(A_CTRL, 1);
    rd(A_CMP, v);  check("R6", "enable promotes buffer", v, 5200);
    rd(A_STAT, v); check("R6", "armed after enable", v[2], 1);
    wait_toggle("R3", 5200, 1'b1);
    check("R5", "flag set by match", irq, 1);
    rd(A_STAT, v); check("R7", "starved after empty match", v[4], 1);
    rd(A_CMP, v);  check("R7", "old value kept", v, 5200);
    reg_write(A_STAT, 0);
    check("R5", "write 0 keeps flag", irq, 1);
    reg_write(A_STAT, 1);
    check("R5", "write 1 clears flag", irq, 0);
    stream_push(6000);
    rd(A_CMP, v);  check("R7", "direct load when starved", v, 6000);
    rd(A_STAT, v); check("R7", "starved cleared", v[4], 0);
    wait_toggle("R3", 6000, 1'b0);
  endtask

  task automatic t_double_buffer;
    logic [31:0] v;
    stream_push(7000);
    stream_push(8000);
    rd(A_STAT, v); check("R6", "second value buffered", v[3], 1);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_data = 9000;
    #1;
    check("R8", "ready low while full", cmp_ready, 0);
    wait_toggle("R3", 7000, 1'b1);
    rd(A_CMP, v);  check("R6", "buffer promoted on match", v, 8000);
    @(negedge clk);
    cmp_valid = 1'b0;
    rd(A_STAT, v); check("R8", "held value taken after match", v[3], 1);
    wait_toggle("R6", 8000, 1'b0);
    wait_toggle("R6", 9000, 1'b1);
    reg_write(A_CMP, 9500);
    reg_write(A_CMP, 9600);
    rd(A_CMP, v);  check("R9", "first sw write goes active", v, 9500);
    reg_write(A_CMP, 9700);
    wait_toggle("R9", 9500, 1'b0);
    rd(A_CMP, v);  check("R9", "overwritten buffer promoted", v, 9700);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    reg_write(A_CTRL, 0);
    check("R10", "level held on disable", oc_out, 0);
    rd(A_CMP, v);  check("R10", "active cleared", v, 0);
    rd(A_STAT, v); check("R10", "armed and full cleared", {27'd0, v[4:2]}, 0);
    check("R10", "ready low when off", cmp_ready, 0);
    repeat (40) @(negedge clk);
    check("R10", "no toggle when off", oc_out, 0);
  endtask

  task automatic t_wrap_cases;
    logic [31:0] v;
    reg_write(A_TIME, 999_999_800);
    reg_write(A_CTRL, 1);
    reg_write(A_CMP, 999_999_990);
    wait_toggle("R3", 0, 1'b1);
    reg_write(A_TIME, 999_999_900);
    reg_write(A_CMP, 10);
    wait_toggle("R3", 25, 1'b0);
    reg_write(A_TIME, 999_999_900);
    reg_write(A_CMP, 0);
    wait_toggle("R3", 0, 1'b1);
    reg_write(A_TIME, 500);
    reg_write(A_CMP, 100);
    reg_write(A_TIME, 999_999_900);
    wait_toggle("R3", 100, 1'b0);
    rd(A_STAT, v); check("R7", "armed after past value fires", v[2], 1);
  endtask

  task automatic t_offset24;
    reg_write(A_TIME, 999_999_949);
    reg_write(A_CMP, 24);
    wait_toggle("R11", 25, 1'b1);
    reg_write(A_TIME, 999_999_899);
    reg_write(A_CMP, 999_999_990);
    wait_toggle("R11", 999_999_999, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL all-requirements watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_count();
    t_enable_and_starve();
    t_double_buffer();
    t_disable();
    t_wrap_cases();
    t_offset24();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule